// File: doc/BRIEF.md
# I2C Master Byte Controller

This block is an I2C bus master that moves a single byte per command. A host programs it through a five-entry register file: two bytes of clock prescale, a control byte, a data byte and a command byte. The host reads back a status byte and the last received byte. From each command the controller builds the bus conditions it asks for. A START or repeated START comes first, then one byte shifted out or in with its acknowledge bit, then an optional STOP. When the command is over, the controller raises an interrupt flag.

Both bus lines work in open-drain fashion. An output-enable high pulls the line low, and the real line level comes back on a separate input. The controller watches the bus to find START and STOP conditions made by any master. While it sends a 1 it compares the line against that 1, and it gives up the bus at once when another master wins arbitration.

Every SCL period is made of five phases of equal length. Each phase lasts prescale+1 system clocks. Software picks the prescale as the system clock divided by five times the wanted SCL rate, minus one.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, all five readable entries read 0x00 and both bus enables are low. Index 0 holds the low prescale byte and index 1 the high byte, and both read back as written. Index 2 keeps only bit 7 (core enable) and bit 6 (interrupt enable) and reads the other bits as 0. A write to index 3 loads the transmit byte, and a read of index 3 returns the last received byte.
- R2: A write to index 4 is a command. Bit 7 asks for START, bit 6 for STOP, bit 5 for a byte read and bit 4 for a byte write. Bit 3 picks NACK instead of ACK after a read, and bit 0 clears the interrupt flag. A read of index 4 gives the status: bit 7 is the received NACK, bit 6 is bus busy, bit 5 is arbitration lost, bit 1 is transfer in progress and bit 0 is the interrupt flag. The in-progress bit reads 1 on the cycle after a command is written.
- R3: Each phase lasts prescale+1 clocks. During a byte, SCL rises once every 5*(prescale+1) clocks and stays high for 2*(prescale+1) clocks.
- R4: A START request pulls SDA low while SCL is high. It works from an idle bus and as a repeated START from a held bus.
- R5: A write sends the data register MSB first, and SDA holds steady while SCL is high. SDA is then released for the acknowledge bit, and the sampled level goes into status bit 7 (1 = NACK).
- R6: A read samples 8 bits MSB first into the received-data register. In the acknowledge slot the controller pulls SDA low when bit 3 was 0 and releases it when bit 3 was 1.
- R7: A STOP request lets SDA rise while SCL is high. After it both lines are released and bus busy reads 0.
- R8: When a command finishes, the in-progress bit drops and the interrupt flag sets. irq_o equals the flag ANDed with the interrupt enable. A command write with bit 0 set clears the flag. If that same write also holds a new command, the flag reads 0 and in-progress reads 1 on the next cycle.
- R9: If SDA is read low in the SCL-high part of a bit the controller is sending as 1, the command ends at once. Status bit 5 and the interrupt flag set, and both lines are released. The arbitration-lost bit clears with the next command.
- R10: When the core enable is cleared, the command ends without raising the flag, the flag clears and both lines are released. Register contents are kept. Command writes made while the core is disabled start nothing.
- R11: Bus busy sets on any START seen on the bus and clears on any STOP, including conditions made by another master.
- R12: After a command that ends without STOP, SCL stays pulled low until the next command.
- R13: A command write that arrives while a transfer is in progress is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Register index 0..4 |
| reg_wr | input | 1 | Write strobe for reg_wdata at reg_addr |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for reg_addr (combinational) |
| irq_o | output | 1 | Level interrupt: flag AND interrupt enable |
| scl_i | input | 1 | Sampled SCL line level |
| scl_oe | output | 1 | High pulls SCL low |
| sda_i | input | 1 | Sampled SDA line level |
| sda_oe | output | 1 | High pulls SDA low |

## Verification
Clearing the interrupt flag and starting a new command can both come from one command write, because bit 0 sits beside the opcode bits. The bench does this by writing 0x11 while the flag from the previous byte is still set. On the very next cycle it expects the flag to read 0, in-progress to read 1 and irq_o to be low. When that byte ends, the flag must rise again. A second pairing is an arbitration loss during the first bit of a byte. That ends the command and sets both the lost bit and the flag in one step, and the bench judges this through the status value 0x61 and the released line enables.

// File: rtl/i2c_byte_master.sv
module i2c_byte_master (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  output logic       irq_o,
  input  logic       scl_i,
  output logic       scl_oe,
  input  logic       sda_i,
  output logic       sda_oe
);
  localparam logic [2:0] PH_LAST = 3'd4;
  localparam logic [2:0] PH_SAMP = 3'd2;

  typedef enum logic [2:0] {S_IDLE, S_START, S_DATA, S_ACK, S_STOP} st_t;
  st_t st;

  logic [7:0]  pre_lo, pre_hi, txr, rxr, sr;
  logic        en, ien, c_sta, c_sto, c_rd, c_wr, c_nack;
  logic        irq_f, al_f, rxack, busy, hold_low, samp, scl_q, sda_q;
  logic [2:0]  phase, bitn;
  logic [15:0] cnt;

  wire [15:0] presc   = {pre_hi, pre_lo};
  wire        tip     = c_sta | c_sto | c_rd | c_wr;
  wire        tick    = (st != S_IDLE) && (cnt == 16'd0);
  wire        last_ph = tick && (phase == PH_LAST);
  wire        samp_ph = tick && (phase == PH_SAMP);
  wire        cmd_wr  = reg_wr && (reg_addr == 3'd4);
  wire        al_hit  = samp_ph && (st == S_DATA) && c_wr && sr[7] && !sda_i;
  wire        seen_start = scl_i && scl_q && sda_q && !sda_i;
  wire        seen_stop  = scl_i && scl_q && !sda_q && sda_i;
  wire        unused_wbits = ^reg_wdata[2:1];

  assign irq_o = irq_f & ien;

  always_comb begin
    case (reg_addr)
      3'd0:    reg_rdata = pre_lo;
      3'd1:    reg_rdata = pre_hi;
      3'd2:    reg_rdata = {en, ien, 6'b0};
      3'd3:    reg_rdata = rxr;
      3'd4:    reg_rdata = {rxack, busy, al_f, 3'b0, tip, irq_f};
      default: reg_rdata = 8'h00;
    endcase
  end

  always_comb begin
    scl_oe = 1'b0;
    sda_oe = 1'b0;
    case (st)
      S_IDLE:  scl_oe = hold_low;
      S_START: begin
        scl_oe = (phase == 3'd0 && hold_low) || phase == PH_LAST;
        sda_oe = phase >= 3'd2;
      end
      S_DATA: begin
        scl_oe = phase < 3'd2 || phase == PH_LAST;
        sda_oe = c_wr && !sr[7];
      end
      S_ACK: begin
        scl_oe = phase < 3'd2 || phase == PH_LAST;
        sda_oe = c_rd && !c_nack;
      end
      S_STOP: begin
        scl_oe = phase == 3'd0;
        sda_oe = phase < 3'd3;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pre_lo <= '0; pre_hi <= '0; txr <= '0; rxr <= '0; sr <= '0;
      en <= 1'b0; ien <= 1'b0;
      c_sta <= 1'b0; c_sto <= 1'b0; c_rd <= 1'b0; c_wr <= 1'b0; c_nack <= 1'b0;
      irq_f <= 1'b0; al_f <= 1'b0; rxack <= 1'b0; busy <= 1'b0;
      hold_low <= 1'b0; samp <= 1'b0; scl_q <= 1'b1; sda_q <= 1'b1;
      phase <= '0; bitn <= '0; cnt <= '0; st <= S_IDLE;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      if (seen_start) busy <= 1'b1;
      else if (seen_stop) busy <= 1'b0;

      if (reg_wr) begin
        case (reg_addr)
          3'd0: pre_lo <= reg_wdata;
          3'd1: pre_hi <= reg_wdata;
          3'd2: begin en <= reg_wdata[7]; ien <= reg_wdata[6]; end
          3'd3: txr <= reg_wdata;
          default: ;
        endcase
      end

      if (!en) begin
        st <= S_IDLE; phase <= '0; cnt <= presc; hold_low <= 1'b0; irq_f <= 1'b0;
        c_sta <= 1'b0; c_sto <= 1'b0; c_rd <= 1'b0; c_wr <= 1'b0;
      end else begin
        if (cmd_wr && reg_wdata[0]) irq_f <= 1'b0;
        if (cmd_wr && !tip) begin
          c_sta <= reg_wdata[7]; c_sto <= reg_wdata[6];
          c_rd  <= reg_wdata[5]; c_wr  <= reg_wdata[4]; c_nack <= reg_wdata[3];
          if (reg_wdata[7:4] != 4'd0) al_f <= 1'b0;
        end

        if (st == S_IDLE)  cnt <= presc;
        else if (tick) begin
          cnt <= presc;
          phase <= (phase == PH_LAST) ? 3'd0 : phase + 3'd1;
        end else cnt <= cnt - 16'd1;

        if (samp_ph) samp <= sda_i;

        case (st)
          S_IDLE: begin
            phase <= '0;
            if (c_sta) st <= S_START;
            else if (c_rd || c_wr) begin st <= S_DATA; sr <= txr; bitn <= '0; end
            else if (c_sto) st <= S_STOP;
          end
          S_START: if (last_ph) begin
            hold_low <= 1'b1;
            if (c_rd || c_wr) begin st <= S_DATA; sr <= txr; bitn <= '0; end
            else if (c_sto) st <= S_STOP;
            else begin
              st <= S_IDLE; irq_f <= 1'b1;
              c_sta <= 1'b0; c_sto <= 1'b0; c_rd <= 1'b0; c_wr <= 1'b0;
            end
          end
          S_DATA: begin
            if (al_hit) begin
              st <= S_IDLE; phase <= '0; hold_low <= 1'b0; al_f <= 1'b1; irq_f <= 1'b1;
              c_sta <= 1'b0; c_sto <= 1'b0; c_rd <= 1'b0; c_wr <= 1'b0;
            end else if (last_ph) begin
              sr <= {sr[6:0], samp};
              bitn <= bitn + 3'd1;
              if (bitn == 3'd7) begin
                st <= S_ACK;
                if (c_rd) rxr <= {sr[6:0], samp};
              end
            end
          end
          S_ACK: if (last_ph) begin
            if (c_wr) rxack <= samp;
            if (c_sto) st <= S_STOP;
            else begin
              st <= S_IDLE; irq_f <= 1'b1;
              c_sta <= 1'b0; c_sto <= 1'b0; c_rd <= 1'b0; c_wr <= 1'b0;
            end
          end
          S_STOP: if (last_ph) begin
            hold_low <= 1'b0; st <= S_IDLE; irq_f <= 1'b1;
            c_sta <= 1'b0; c_sto <= 1'b0; c_rd <= 1'b0; c_wr <= 1'b0;
          end
          default: st <= S_IDLE;
        endcase
      end
    end
  end

  assert_flag_at_end_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_f) |-> ($past(tip) && !tip));

  assert_lost_releases_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(al_f) |-> (irq_f && !tip && !scl_oe && !sda_oe));

  assert_disable_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> (!tip && !scl_oe && !sda_oe));

  assert_busy_clear_scl_high_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> $past(scl_i));

  assert_sda_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_DATA && phase == 3'd3 && $past(st) == S_DATA) |-> $stable(sda_oe));
endmodule

// File: tb/i2c_byte_master_tb_top.sv
module i2c_byte_master_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [2:0] reg_addr = '0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic irq_o, scl_oe, sda_oe;
  logic slv_tx = 1'b0, slv_ack = 1'b1, ext_low = 1'b0;
  logic [7:0] slv_byte = '0;
  logic slv_low;
  int checks = 0, fails = 0;

  always #4 clk = ~clk;

  wire scl_line = !scl_oe;
  wire sda_line = !(sda_oe || slv_low || ext_low);

  i2c_byte_master dut_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o),
    .scl_i(scl_line), .scl_oe(scl_oe), .sda_i(sda_line), .sda_oe(sda_oe));

  int bit_idx = -1, cyc = 0, rise_cyc = 0, per = 0, hi_len = 0;
  logic prev_scl = 1'b1, prev_sda = 1'b1, ack_seen = 1'b1;
  logic [7:0] cap = '0;

  always @(negedge clk) begin
    cyc++;
    if (prev_scl && scl_line && prev_sda != sda_line) bit_idx = -1;
    else if (prev_scl && !scl_line) begin
      bit_idx = (bit_idx == 8) ? 0 : bit_idx + 1;
      hi_len = cyc - rise_cyc;
    end else if (!prev_scl && scl_line) begin
      per = cyc - rise_cyc;
      rise_cyc = cyc;
      if (bit_idx >= 0 && bit_idx < 8) cap = {cap[6:0], sda_line};
      if (bit_idx == 8) ack_seen = sda_line;
    end
    prev_scl = scl_line;
    prev_sda = sda_line;
  end

  always_comb begin
    if (bit_idx >= 0 && bit_idx < 8) slv_low = slv_tx && !slv_byte[7 - bit_idx];
    else slv_low = (bit_idx == 8) && !slv_tx && slv_ack;
  end

  localparam int NV = 8;
  localparam logic [18:0] VEC [NV] = '{
    {3'd0, 8'h34, 8'h34}, {3'd1, 8'h12, 8'h12}, {3'd2, 8'hFF, 8'hC0},
    {3'd2, 8'h00, 8'h00}, {3'd3, 8'hA5, 8'h00}, {3'd0, 8'h01, 8'h01},
    {3'd1, 8'h00, 8'h00}, {3'd2, 8'hC0, 8'hC0}};

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    reg_addr = a;
    #1 v = reg_rdata;
  endtask

  task automatic wait_done();
    logic [7:0] s;
    int n = 0;
    do begin
      @(negedge clk);
      rd(3'd4, s);
      n++;
    end while (s[1] && n < 5000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v);
      chk("R1 reset register", v, 0);
    end
    chk("R1 reset scl_oe", scl_oe, 0);
    chk("R1 reset sda_oe", sda_oe, 0);
    chk("R8 reset irq", irq_o, 0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][18:16], VEC[i][15:8]);
      rd(VEC[i][18:16], v);
      chk("R1 register readback", v, int'(VEC[i][7:0]));
    end

    // START + address write
    wr(3'd3, 8'hA0);
    wr(3'd4, 8'h91);
    rd(3'd4, v);
    chk("R2 in-progress after command", v & 8'h03, 8'h02);
    wait_done();
    rd(3'd4, v);
    chk("R4 R8 status after start+write", v, 8'h41);
    chk("R8 irq high", irq_o, 1);
    chk("R5 byte sent MSB first", cap, 8'hA0);
    chk("R12 scl held low", scl_oe, 1);
    chk("R3 scl period", per, 10);
    chk("R3 scl high time", hi_len, 4);

    // clear flag and start write in one command
    wr(3'd3, 8'h3C);
    wr(3'd4, 8'h11);
    rd(3'd4, v);
    chk("R8 clear+start same write", v & 8'h03, 8'h02);
    chk("R8 irq low after clear", irq_o, 0);
    wait_done();
    rd(3'd4, v);
    chk("R8 flag sets again", v, 8'h41);
    chk("R5 second byte", cap, 8'h3C);

    // NACK from slave
    slv_ack = 1'b0;
    wr(3'd3, 8'h55);
    wr(3'd4, 8'h11);
    wait_done();
    rd(3'd4, v);
    chk("R5 nack recorded", v, 8'hC1);
    slv_ack = 1'b1;

    wr(3'd4, 8'h01);
    rd(3'd4, v);
    chk("R8 clear only", v, 8'hC0);
    chk("R8 irq after clear only", irq_o, 0);

    // command while busy is dropped
    wr(3'd3, 8'h0F);
    wr(3'd4, 8'h11);
    wr(3'd4, 8'h41);
    wait_done();
    repeat (20) @(negedge clk);
    rd(3'd4, v);
    chk("R13 stop dropped status", v, 8'h41);
    chk("R13 scl still held", scl_oe, 1);

    // repeated START + reads
    wr(3'd3, 8'hA1);
    wr(3'd4, 8'h91);
    wait_done();
    slv_tx = 1'b1; slv_byte = 8'h5A;
    wr(3'd4, 8'h21);
    wait_done();
    rd(3'd3, v);
    chk("R6 read with ack data", v, 8'h5A);
    chk("R6 master ack driven low", ack_seen, 0);
    slv_byte = 8'hC3;
    wr(3'd4, 8'h29);
    wait_done();
    rd(3'd3, v);
    chk("R6 read with nack data", v, 8'hC3);
    chk("R6 master nack released", ack_seen, 1);
    slv_tx = 1'b0;

    // STOP
    wr(3'd4, 8'h41);
    wait_done();
    rd(3'd4, v);
    chk("R7 status after stop", v, 8'h01);
    chk("R7 scl released", scl_oe, 0);
    chk("R7 sda released", sda_oe, 0);

    // timing with prescale 2
    wr(3'd0, 8'h02);
    wr(3'd3, 8'hA0);
    wr(3'd4, 8'h91);
    wait_done();
    chk("R3 period prescale 2", per, 15);
    chk("R3 high time prescale 2", hi_len, 6);
    wr(3'd4, 8'h41);
    wait_done();
    wr(3'd0, 8'h01);

    // arbitration loss
    wr(3'd3, 8'hA0);
    wr(3'd4, 8'h91);
    wait_done();
    wr(3'd3, 8'hFF);
    ext_low = 1'b1;
    wr(3'd4, 8'h11);
    wait_done();
    rd(3'd4, v);
    chk("R9 status after loss", v, 8'h61);
    chk("R9 scl released", scl_oe, 0);
    chk("R9 sda released", sda_oe, 0);
    chk("R9 irq raised", irq_o, 1);
    ext_low = 1'b0;
    repeat (4) @(negedge clk);
    rd(3'd4, v);
    chk("R11 other master stop clears busy", v, 8'h21);

    // external START/STOP
    ext_low = 1'b1;
    repeat (4) @(negedge clk);
    rd(3'd4, v);
    chk("R11 external start sets busy", v & 8'h40, 8'h40);
    ext_low = 1'b0;
    repeat (4) @(negedge clk);
    rd(3'd4, v);
    chk("R11 external stop clears busy", v & 8'h40, 8'h00);

    // disable mid transfer
    wr(3'd3, 8'hA0);
    wr(3'd4, 8'h91);
    repeat (25) @(negedge clk);
    wr(3'd2, 8'h00);
    repeat (2) @(negedge clk);
    rd(3'd4, v);
    chk("R10 command ended, flag clear", v & 8'h03, 8'h00);
    chk("R10 scl released", scl_oe, 0);
    chk("R10 sda released", sda_oe, 0);
    rd(3'd0, v);
    chk("R10 prescale kept", v, 8'h01);
    wr(3'd4, 8'h11);
    rd(3'd4, v);
    chk("R10 command ignored when off", v & 8'h02, 8'h00);
    chk("R10 irq low when off", irq_o, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule